// File: doc/BRIEF.md
# Packet-Marked Transmit Queue

This block is the byte queue that sits between a microcontroller and a bit-serial HDLC framer. The processor pushes bytes through one of two write selects. A plain write stores the byte as packet body. A last-byte write stores it as the end of a packet. Both selects fill the same 64-entry storage. Each entry keeps a ninth flag that tells the framer where a packet ends, so several whole packets and one partly written packet can wait in the queue together.

The framer sees the head entry directly (first-word fall-through) and takes it with a pop strobe. The processor reads a live count of free entries and programs a space threshold. Each pop that leaves more free space than the threshold latches an interrupt, so software can refill the queue in bursts. An abort input discards everything queued. A write to a full queue is dropped and raises a sticky overflow flag.

Top module: `pkt_txq`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `free_cnt_o`=64, `irq_o`=0 and `ovf_o`=0.
- R2: A write with `wr_last_i`=0 stores the byte with end flag 0. A write with `wr_last_i`=1 stores it with end flag 1. The head entry appears on `pop_data_o`/`pop_last_o` whenever `empty_o`=0, and bytes leave in the order they were written.
- R3: Several complete packets plus a partial one can be queued together, and each byte keeps its own end flag through to the pop port.
- R4: `free_cnt_o` equals 64 minus the number of stored entries, one cycle after each accepted write or pop.
- R5: An accepted pop sets `irq_o` on the following cycle when the resulting free count is strictly greater than `thresh_i`. A resulting count equal to `thresh_i` does not set it.
- R6: Writes never set `irq_o`. Once set, `irq_o` stays high until `irq_clr_i` is pulsed. A qualifying pop in the same cycle as `irq_clr_i` wins, and `irq_o` stays 1.
- R7: `flush_i` empties the queue on the next cycle (`free_cnt_o`=64, `empty_o`=1). A write or pop in the same cycle is discarded.
- R8: A write while the queue is full is dropped, `free_cnt_o` stays 0, and `ovf_o` goes to 1 and stays there until `ovf_clr_i` is pulsed.
- R9: A pop while the queue is empty has no effect: the count stays 64 and the next byte written is the next byte popped.
- R10: A write and a pop both accepted in the same cycle leave `free_cnt_o` unchanged.
- R11: Data and end flags stay intact across the wrap of the storage pointers over the full 64 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| wr_last_i | input | 1 | Write select: 1 = last byte of packet |
| wr_data_i | input | 8 | CPU write byte |
| free_cnt_o | output | 7 | Number of free entries (0..64) |
| thresh_i | input | 7 | Free-space interrupt threshold |
| pop_i | input | 1 | Framer pop strobe |
| pop_data_o | output | 8 | Head byte |
| pop_last_o | output | 1 | Head end-of-packet flag |
| empty_o | output | 1 | Queue empty |
| flush_i | input | 1 | Abort: discard all contents |
| irq_clr_i | input | 1 | Clear threshold interrupt |
| ovf_clr_i | input | 1 | Clear overflow flag |
| irq_o | output | 1 | Threshold interrupt, sticky |
| ovf_o | output | 1 | Write overflow flag, sticky |

## Verification
The CPU write and the framer pop can land in the same cycle. The count must then hold still while both the stored and the removed bytes stay correct. The stimulus table provokes this mid-stream with a combined write-and-pop step. The step is judged by the unchanged free count and by the order in which the written byte later leaves the queue. The abort can also collide with a write. A flush issued together with a write is checked through an empty queue and through a later pop that returns only the byte written after the flush. The interrupt clear racing a qualifying pop is provoked the same way, and is judged by `irq_o` staying high.

// File: rtl/pkt_txq_pkg.sv
package pkt_txq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              eop;
    logic [DATA_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
  import pkt_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       we_i,
  input  logic [AW-1:0] waddr_i,
  input  txq_entry_t wdata_i,
  input  logic [AW-1:0] raddr_i,
  output txq_entry_t rdata_o
);
  txq_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          wr_drop_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] used_o,
  output logic [CW-1:0] used_nxt_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] used_q, used_d;
  logic          full;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if ((1 << AW) == DEPTH) return p + 1'b1;
    else                    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  assign full      = (used_q == DEPTH_C);
  assign empty_o   = (used_q == '0);
  assign wr_ok_o   = wr_en_i && !full && !flush_i;
  assign rd_ok_o   = pop_i && !empty_o && !flush_i;
  assign wr_drop_o = wr_en_i && full && !flush_i;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    used_d   = used_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      used_d   = '0;
    end else begin
      if (wr_ok_o) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (rd_ok_o) rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({wr_ok_o, rd_ok_o})
        2'b10:   used_d = used_q + 1'b1;
        2'b01:   used_d = used_q - 1'b1;
        default: used_d = used_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      used_q   <= used_d;
    end
  end

  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign used_o     = used_q;
  assign used_nxt_o = used_d;
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_ok_i,
  input  logic          wr_drop_i,
  input  logic [CW-1:0] used_nxt_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          irq_clr_i,
  input  logic          ovf_clr_i,
  output logic          irq_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] free_nxt;
  logic          irq_set;

  assign free_nxt = DEPTH_C - used_nxt_i;
  // only framer reads qualify
  assign irq_set  = rd_ok_i && (free_nxt > thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      if (irq_set)        irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (wr_drop_i)      ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_txq.sv
module pkt_txq
  import pkt_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_last_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CW-1:0]     free_cnt_o,
  input  logic [CW-1:0]     thresh_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_last_o,
  output logic              empty_o,
  input  logic              flush_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          wr_ok, rd_ok, wr_drop;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used, used_nxt;
  txq_entry_t    wr_ent, rd_ent;

  assign wr_ent.eop  = wr_last_i;
  assign wr_ent.data = wr_data_i;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .pop_i      (pop_i),
    .flush_i    (flush_i),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .wr_drop_o  (wr_drop),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .used_o     (used),
    .used_nxt_o (used_nxt),
    .empty_o    (empty_o)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_ptr),
    .wdata_i (wr_ent),
    .raddr_i (rd_ptr),
    .rdata_o (rd_ent)
  );

  txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_ok_i    (rd_ok),
    .wr_drop_i  (wr_drop),
    .used_nxt_i (used_nxt),
    .thresh_i   (thresh_i),
    .irq_clr_i  (irq_clr_i),
    .ovf_clr_i  (ovf_clr_i),
    .irq_o      (irq_o),
    .ovf_o      (ovf_o)
  );

  assign free_cnt_o = DEPTH_C - used;
  assign pop_data_o = rd_ent.data;
  assign pop_last_o = rd_ent.eop;
endmodule

// File: rtl/pkt_txq_chk.sv
module pkt_txq_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          pop_i,
  input logic          flush_i,
  input logic          empty_o,
  input logic [CW-1:0] free_cnt_o,
  input logic          irq_o,
  input logic          ovf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  always_comb begin
    if (rst_ni) assert_empty_count_R4: assert (empty_o == (free_cnt_o == DEPTH_C));
  end

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (free_cnt_o == DEPTH_C) && empty_o);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pop_i && !flush_i && free_cnt_o == '0) |=> ovf_o && (free_cnt_o == '0));

  assert_empty_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !wr_en_i && !flush_i) |=> empty_o);

  assert_wr_pop_balance_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pop_i && !empty_o && free_cnt_o != '0 && !flush_i) |=> $stable(free_cnt_o));

  assert_irq_from_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pop_i && !empty_o && !flush_i));
endmodule

bind pkt_txq pkt_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .pop_i      (pop_i),
  .flush_i    (flush_i),
  .empty_o    (empty_o),
  .free_cnt_o (free_cnt_o),
  .irq_o      (irq_o),
  .ovf_o      (ovf_o)
);

// File: tb/tb_pkt_txq.sv
`timescale 1ns/1ps
module tb_pkt_txq;
  logic       clk_i = 0, rst_ni = 0;
  logic       wr_en_i = 0, wr_last_i = 0, pop_i = 0, flush_i = 0;
  logic       irq_clr_i = 0, ovf_clr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [6:0] thresh_i = 7'd62;
  logic [6:0] free_cnt_o;
  logic [7:0] pop_data_o;
  logic       pop_last_o, empty_o, irq_o, ovf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pkt_txq dut (.*);

  // op: 0 write, 1 write-last, 2 pop, 3 write+pop
  // {op, wdata, exp_pop_data, exp_pop_last, exp_free, exp_irq}
  localparam logic [26:0] VEC [11] = '{
    {2'd0, 8'h11, 8'h00, 1'b0, 7'd63, 1'b0},
    {2'd0, 8'h22, 8'h00, 1'b0, 7'd62, 1'b0},
    {2'd1, 8'h33, 8'h00, 1'b0, 7'd61, 1'b0},
    {2'd1, 8'h44, 8'h00, 1'b0, 7'd60, 1'b0},
    {2'd0, 8'h55, 8'h00, 1'b0, 7'd59, 1'b0},
    {2'd2, 8'h00, 8'h11, 1'b0, 7'd60, 1'b0},
    {2'd3, 8'h66, 8'h22, 1'b0, 7'd60, 1'b0},
    {2'd2, 8'h00, 8'h33, 1'b1, 7'd61, 1'b0},
    {2'd2, 8'h00, 8'h44, 1'b1, 7'd62, 1'b0},
    {2'd2, 8'h00, 8'h55, 1'b0, 7'd63, 1'b1},
    {2'd2, 8'h00, 8'h66, 1'b0, 7'd64, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d, input logic last);
    wr_en_i = 1; wr_last_i = last; wr_data_i = d;
    step();
    wr_en_i = 0; wr_last_i = 0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic last);
    chk(req, "pop data", pop_data_o, d);
    chk(req, "pop last", pop_last_o, last);
    pop_i = 1;
    step();
    pop_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    step();
    rst_ni = 1;
    step();
    // R1 reset state
    chk("R1", "empty", empty_o, 1);
    chk("R1", "free", free_cnt_o, 64);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "ovf", ovf_o, 0);

    // table: R2 R3 R4 R5 R10
    for (int i = 0; i < 11; i++) begin
      logic [1:0] op;
      op = VEC[i][26:25];
      wr_en_i   = (op != 2'd2);
      wr_last_i = (op == 2'd1);
      wr_data_i = VEC[i][24:17];
      pop_i     = op[1];
      if (op[1]) begin
        chk("R2", "table pop data", pop_data_o, VEC[i][16:9]);
        chk("R3", "table pop last", pop_last_o, VEC[i][8]);
      end
      step();
      wr_en_i = 0; wr_last_i = 0; pop_i = 0;
      chk(op == 2'd3 ? "R10" : "R4", "table free", free_cnt_o, VEC[i][7:1]);
      chk("R5", "table irq", irq_o, VEC[i][0]);
    end

    // R6 clear, then writes do not set irq
    irq_clr_i = 1; step(); irq_clr_i = 0;
    chk("R6", "irq cleared", irq_o, 0);
    thresh_i = 7'd0;
    wr(8'h01, 0); wr(8'h02, 0); wr(8'h03, 1);
    chk("R6", "irq after writes", irq_o, 0);
    // set wins over clear
    irq_clr_i = 1;
    pop_chk("R6", 8'h01, 0);
    irq_clr_i = 0;
    chk("R6", "set beats clear", irq_o, 1);
    step();
    chk("R6", "irq sticky", irq_o, 1);
    irq_clr_i = 1; step(); irq_clr_i = 0;

    // R5 equality does not set: free after pop 63, thresh 63
    thresh_i = 7'd63;
    pop_chk("R5", 8'h02, 0);
    chk("R5", "equal no irq", irq_o, 0);

    // R7 flush with simultaneous write
    flush_i = 1; wr(8'hEE, 1); flush_i = 0;
    chk("R7", "free after flush", free_cnt_o, 64);
    chk("R7", "empty after flush", empty_o, 1);
    wr(8'h5A, 1);
    pop_chk("R7", 8'h5A, 1);
    chk("R7", "empty again", empty_o, 1);

    // R9 empty pop ignored
    pop_i = 1; step(); pop_i = 0;
    chk("R9", "free", free_cnt_o, 64);
    chk("R9", "empty", empty_o, 1);
    wr(8'hA5, 0);
    pop_chk("R9", 8'hA5, 0);

    // R8 / R11: pointers at 2, fill 64 (wraps), overflow, drain
    thresh_i = 7'd64;
    for (int i = 0; i < 64; i++) wr(8'(i * 3 + 7), (i % 8) == 7);
    chk("R8", "free at full", free_cnt_o, 0);
    chk("R8", "ovf before", ovf_o, 0);
    wr(8'hFF, 1);
    chk("R8", "free after drop", free_cnt_o, 0);
    chk("R8", "ovf set", ovf_o, 1);
    step();
    chk("R8", "ovf sticky", ovf_o, 1);
    for (int i = 0; i < 64; i++) pop_chk("R11", 8'(i * 3 + 7), (i % 8) == 7);
    chk("R11", "empty after drain", empty_o, 1);
    chk("R8", "ovf still set", ovf_o, 1);
    ovf_clr_i = 1; step(); ovf_clr_i = 0;
    chk("R8", "ovf cleared", ovf_o, 0);

    finish_run();
  end
endmodule